// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It pulls words from a transmit queue through a valid/ready handshake and shifts them out MSB first on the data-out line. For every word sent it shifts in one word from the data-in line and offers that word to a receive queue through a second valid/ready handshake. The bit clock comes from a programmable divider, so one serial half-period lasts a whole number of system clocks.

Software-facing controls arrive as plain level inputs. These inputs set the enable, the clock polarity, the launch edge, the sample point, the word size, the divider value and the automatic chip-select. The queues themselves live outside the block. A word that completes while the receive side still holds an unread word is dropped, and the engine signals this with a one-cycle overflow pulse. The engine does not stall in that case. When the transmit side keeps data ready, words follow each other with no idle bit between them.

Top module: `spi_shift_engine`

## Requirements
- R1: Out of reset, `rx_valid_o` and `rx_ovf_o` are low, `cs_no` is high while `tx_valid_i` is low, `sck_o` equals `cpol_i`, and `tx_ready_o` is high when `on_i` is high.
- R2: Each serial half-period lasts `baud_i`+1 system clocks, so one bit takes 2*(`baud_i`+1) clocks and the SCK rate is the system clock divided by 2*(`baud_i`+1). The first bit begins in the cycle after the word is accepted.
- R3: The idle level of `sck_o` is `cpol_i`: low when `cpol_i`=0 and high when `cpol_i`=1.
- R4: With `cke_i`=1, the first half of every bit is at the idle level and the second half is active, so data changes on the active-to-idle edge. With `cke_i`=0, the first half is active and the second half is idle, so data changes on the idle-to-active edge.
- R5: `wsize_i` encodes the word length as 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. The engine sends bits [n-1:0] of `tx_data_i`, MSB first, and holds each bit on `mosi_o` for a whole bit time.
- R6: With `smp_i`=0, `miso_i` is sampled in the last clock of the first half of each bit. With `smp_i`=1, it is sampled in the last clock of the second half. The received word sits in the low n bits of `rx_data_o`, MSB first, and the bits above it are zero.
- R7: Each completed word raises `rx_valid_o` on the clock edge that ends its last bit. `rx_valid_o` and `rx_data_o` then hold until `rx_ready_i` is high.
- R8: If `tx_valid_i` is high when a word ends, the next word starts at once with no idle cycles, and `sck_o` keeps its pattern across the boundary.
- R9: A word that completes while `rx_valid_o` is high and `rx_ready_i` is low is dropped. `rx_ovf_o` pulses for one cycle, the older word stays on `rx_data_o`, and shifting does not stop.
- R10: With `auto_cs_i`=1 and `on_i`=1, `cs_no` is low while a word is shifting or `tx_valid_i` is high, and is high otherwise. With `auto_cs_i`=0, `cs_no` stays high.
- R11: With `on_i` low, `tx_ready_o` is low. Dropping `on_i` in the middle of a word aborts it with no receive word, and `sck_o` is back at `cpol_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_i | input | 1 | Engine enable |
| cpol_i | input | 1 | SCK idle level |
| cke_i | input | 1 | 1: launch on active-to-idle edge; 0: launch on idle-to-active edge |
| smp_i | input | 1 | 1: sample at end of bit; 0: sample mid-bit |
| wsize_i | input | 2 | Word length code (0=8, 1=16, 2=32) |
| baud_i | input | 9 | Divider value; half-period = baud_i+1 clocks |
| auto_cs_i | input | 1 | Enable automatic chip-select |
| tx_data_i | input | 32 | Word from the transmit queue |
| tx_valid_i | input | 1 | Transmit queue not empty |
| tx_ready_o | output | 1 | Word taken this cycle when valid |
| rx_data_o | output | 32 | Received word |
| rx_valid_o | output | 1 | Received word pending |
| rx_ready_i | input | 1 | Receive queue accepts the word |
| rx_ovf_o | output | 1 | One-cycle pulse when a received word is dropped |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip-select, active low |

## Verification
The bench sweeps every mode and word-size combination over three divider values. It gives `miso_i` different values in the two halves of each bit, so a sample taken in the wrong half returns the other pattern word. A wrong launch edge or polarity would show as SCK mismatches in a specific half of the bit. An off-by-one divider would shift every later edge, and a wrong alignment for short words would send or return the wrong byte. Further tests cover back-to-back words, where a design that inserts a gap bit would lose SCK alignment on the second word. They also cover a receive side that refuses a second word, where a design that stalls or overwrites the pending word would be caught. The last case is an enable drop in mid-word; a design that finishes the word or leaves SCK active would be flagged.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    WS_8    = 2'd0,
    WS_16   = 2'd1,
    WS_32   = 2'd2,
    WS_RSVD = 2'd3
  } wsize_e;

  function automatic int unsigned ws_bits(logic [1:0] ws);
    case (wsize_e'(ws))
      WS_8:    return 8;
      WS_16:   return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int BAUD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] cnt_q;

  // >= keeps the tick alive if the divider shrinks mid-word
  assign tick_o = run_i && (cnt_q >= baud_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int MAX_W = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_W-1:0] load_data_i,
  input  logic [CNT_W-1:0] load_bits_i,
  input  logic [CNT_W-1:0] cur_bits_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [MAX_W-1:0] rx_word_o
);
  logic [MAX_W-1:0] tx_sh_q, rx_sh_q, rx_next, rx_mask;

  assign mosi_o  = tx_sh_q[MAX_W-1];
  assign rx_next = {rx_sh_q[MAX_W-2:0], miso_i};
  assign rx_mask = {MAX_W{1'b1}} >> (MAX_W - int'(cur_bits_i));
  // include a sample taken in the same cycle the word ends
  assign rx_word_o = (sample_i ? rx_next : rx_sh_q) & rx_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_sh_q <= '0;
    else if (load_i)   tx_sh_q <= load_data_i << (MAX_W - int'(load_bits_i));
    else if (shift_i)  tx_sh_q <= tx_sh_q << 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_sh_q <= '0;
    else if (sample_i)  rx_sh_q <= rx_next;
  end
endmodule

// File: rtl/spi_eng_rx.sv
module spi_eng_rx #(
  parameter int MAX_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [MAX_W-1:0] push_data_i,
  input  logic             rx_ready_i,
  output logic             rx_valid_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             ovf_o
);
  logic drain;
  assign drain = rx_valid_o && rx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      ovf_o      <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (drain) rx_valid_o <= 1'b0;
      if (push_i) begin
        if (rx_valid_o && !drain) begin
          ovf_o <= 1'b1;
        end else begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= push_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int MAX_W  = 32,
  parameter int BAUD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              on_i,
  input  logic              cpol_i,
  input  logic              cke_i,
  input  logic              smp_i,
  input  logic [1:0]        wsize_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              auto_cs_i,
  input  logic [MAX_W-1:0]  tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [MAX_W-1:0]  rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic              rx_ovf_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);
  import spi_eng_pkg::*;

  localparam int CNT_W = $clog2(MAX_W + 1);

  logic             busy_q, half_q;
  logic [CNT_W-1:0] bit_q, nbits_q, load_bits;
  logic             tick, half_end, last_bit, word_end;
  logic             load, sample, shift_bit, push;
  logic             mosi_raw;
  logic [MAX_W-1:0] rx_word;

  assign load_bits  = CNT_W'(ws_bits(wsize_i));
  assign half_end   = tick && half_q;
  assign last_bit   = (bit_q == nbits_q - 1'b1);
  assign word_end   = half_end && last_bit;
  assign tx_ready_o = on_i && (!busy_q || word_end);
  assign load       = tx_valid_i && tx_ready_o;
  assign sample     = tick && (half_q == smp_i);
  assign shift_bit  = half_end;
  assign push       = word_end && on_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      half_q  <= 1'b0;
      bit_q   <= '0;
      nbits_q <= CNT_W'(8);
    end else if (!on_i) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      half_q  <= 1'b0;
      bit_q   <= '0;
      nbits_q <= load_bits;
    end else if (word_end) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
    end else if (tick) begin
      half_q <= ~half_q;
      if (half_end) bit_q <= bit_q + 1'b1;
    end
  end

  spi_eng_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .baud_i (baud_i),
    .tick_o (tick)
  );

  spi_eng_shift #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (tx_data_i),
    .load_bits_i (load_bits),
    .cur_bits_i  (nbits_q),
    .shift_i     (shift_bit),
    .sample_i    (sample),
    .miso_i      (miso_i),
    .mosi_o      (mosi_raw),
    .rx_word_o   (rx_word)
  );

  spi_eng_rx #(.MAX_W(MAX_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (rx_word),
    .rx_ready_i  (rx_ready_i),
    .rx_valid_o  (rx_valid_o),
    .rx_data_o   (rx_data_o),
    .ovf_o       (rx_ovf_o)
  );

  // active half: second half when cke_i=1, first half when cke_i=0
  assign sck_o  = cpol_i ^ (busy_q && (half_q == cke_i));
  assign mosi_o = busy_q ? mosi_raw : 1'b1;
  assign cs_no  = !(auto_cs_i && on_i && (busy_q || tx_valid_i));
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int MAX_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             on_i,
  input logic             cpol_i,
  input logic             auto_cs_i,
  input logic             tx_ready_o,
  input logic             rx_valid_o,
  input logic             rx_ready_i,
  input logic [MAX_W-1:0] rx_data_o,
  input logic             rx_ovf_o,
  input logic             sck_o,
  input logic             cs_no,
  input logic             busy_q
);
  assert_off_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_i |=> (sck_o == cpol_i));

  assert_ready_needs_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> on_i);

  assert_ovf_keeps_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o |-> rx_valid_o);

  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  assert_rx_after_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(busy_q));

  assert_cs_in_word_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && auto_cs_i && on_i) |-> !cs_no);
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.MAX_W(MAX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .on_i       (on_i),
  .cpol_i     (cpol_i),
  .auto_cs_i  (auto_cs_i),
  .tx_ready_o (tx_ready_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .rx_data_o  (rx_data_o),
  .rx_ovf_o   (rx_ovf_o),
  .sck_o      (sck_o),
  .cs_no      (cs_no),
  .busy_q     (busy_q)
);

// File: tb/spi_shift_engine_tb.sv
`timescale 1ns/1ps
module spi_shift_engine_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        on_i = 1'b1, cpol_i = 1'b0, cke_i = 1'b1, smp_i = 1'b0;
  logic [1:0]  wsize_i = 2'd0;
  logic [8:0]  baud_i = '0;
  logic        auto_cs_i = 1'b1;
  logic [31:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o;
  logic [31:0] rx_data_o;
  logic        rx_valid_o, rx_ready_i = 1'b1, rx_ovf_o;
  logic        sck_o, mosi_o, miso_i = 1'b0, cs_no;

  int n_vec = 0, n_bad = 0, rx_cnt = 0;
  logic [31:0] rx_log [0:15];

  always #4 clk_i = ~clk_i;

  spi_shift_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .on_i(on_i), .cpol_i(cpol_i), .cke_i(cke_i),
    .smp_i(smp_i), .wsize_i(wsize_i), .baud_i(baud_i), .auto_cs_i(auto_cs_i),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .rx_ovf_o(rx_ovf_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_no(cs_no)
  );

  always @(posedge clk_i)
    if (rst_ni && rx_valid_o && rx_ready_i) begin
      rx_log[rx_cnt[3:0]] <= rx_data_o;
      rx_cnt <= rx_cnt + 1;
    end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  // Runs the cycles of one accepted word; called right after the accept edge.
  task automatic word_cycles(input int n, input int h, input logic [31:0] txw,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic keep_valid, input logic [31:0] nxt);
    int e_sck = 0, e_mosi = 0, e_cs = 0;
    for (int c = 0; c < n * 2 * h; c++) begin
      int k;
      logic second;
      @(negedge clk_i);
      k = c / (2 * h);
      second = (c % (2 * h)) >= h;
      if (c == 0) begin tx_valid_i = keep_valid; tx_data_i = nxt; end
      miso_i = second ? b[n-1-k] : a[n-1-k];
      if (sck_o !== (cpol_i ^ (second == cke_i))) e_sck++;
      if (mosi_o !== txw[n-1-k]) e_mosi++;
      if (auto_cs_i && cs_no !== 1'b0) e_cs++;
      @(posedge clk_i);
    end
    check("R2 R3 R4 sck pattern errors", e_sck, 0);
    check("R5 mosi bit errors", e_mosi, 0);
    if (auto_cs_i) check("R10 cs low during word", e_cs, 0);
  endtask

  task automatic start_word(input logic [31:0] w);
    @(negedge clk_i);
    tx_valid_i = 1'b1;
    tx_data_i  = w;
    @(posedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk_i);
    check("R1 sck idle in reset cpol=0", sck_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 rx_valid after reset", rx_valid_o, 0);
    check("R1 rx_ovf after reset", rx_ovf_o, 0);
    check("R1 cs high after reset", cs_no, 1);
    check("R1 tx_ready after reset", tx_ready_o, 1);
    cpol_i = 1'b1;
    #1 check("R3 idle sck follows cpol=1", sck_o, 1);

    // near-exhaustive sweep
    for (int ws = 0; ws < 3; ws++)
      for (int pm = 0; pm < 8; pm++)
        for (int bd = 0; bd < 3; bd++) begin
          int n;
          logic [31:0] w, a, b;
          n = 8 << ws;
          w = (32'h9E37_79B9 * (idx + 1)) & msk(n);
          a = ((w << 3) ^ 32'h5A5A_C3C3) & msk(n);
          b = (~w ^ 32'h0F0F_1234) & msk(n);
          @(negedge clk_i);
          wsize_i = ws[1:0]; cpol_i = pm[0]; cke_i = pm[1]; smp_i = pm[2];
          baud_i = 9'(bd); auto_cs_i = idx[0];
          start_word(w | (32'hFFFF_FFFF & ~msk(n)));
          word_cycles(n, bd + 1, w, a, b, 1'b0, 32'h0);
          @(negedge clk_i);
          check("R6 R7 rx_valid after word", rx_valid_o, 1);
          check(smp_i ? "R6 rx word, end sample" : "R6 rx word, mid sample",
                rx_data_o, smp_i ? b : a);
          check("R3 sck idle after word", sck_o, cpol_i);
          if (auto_cs_i) check("R10 cs released after drain", cs_no, 1);
          else           check("R10 cs high when auto off", cs_no, 1);
          idx++;
        end

    // back-to-back words, 8 bit, mode 0, baud 1
    @(negedge clk_i);
    wsize_i = 2'd0; cpol_i = 0; cke_i = 1; smp_i = 0; baud_i = 9'd1; auto_cs_i = 1;
    rx_cnt = 0;
    start_word(32'h0000_00B4);
    word_cycles(8, 2, 32'hB4, 32'h5E, 32'h00, 1'b1, 32'h0000_0027);
    word_cycles(8, 2, 32'h27, 32'h91, 32'h00, 1'b0, 32'h0);
    repeat (2) @(negedge clk_i);
    check("R8 two words received", rx_cnt, 2);
    check("R8 first chained word", rx_log[0], 32'h5E);
    check("R8 second chained word", rx_log[1], 32'h91);

    // overflow: receive side blocked
    @(negedge clk_i);
    rx_ready_i = 1'b0; baud_i = 9'd0;
    start_word(32'h0000_0011);
    word_cycles(8, 1, 32'h11, 32'h3C, 32'h00, 1'b0, 32'h0);
    start_word(32'h0000_0022);
    word_cycles(8, 1, 32'h22, 32'hC3, 32'h00, 1'b0, 32'h0);
    @(negedge clk_i);
    check("R9 overflow pulse", rx_ovf_o, 1);
    check("R9 older word kept", rx_data_o, 32'h3C);
    check("R9 engine not stalled", tx_ready_o, 1);
    @(negedge clk_i);
    check("R9 overflow is one cycle", rx_ovf_o, 0);
    rx_cnt = 0;
    rx_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R9 only one word delivered", rx_cnt, 1);
    check("R9 delivered word", rx_log[0], 32'h3C);

    // abort by disable in mid-word
    cpol_i = 1'b1; cke_i = 1'b1; baud_i = 9'd1;
    rx_cnt = 0;
    start_word(32'h0000_00F0);
    @(negedge clk_i); tx_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R4 active half before abort", sck_o, 0);
    on_i = 1'b0;
    #1 check("R11 tx_ready low when off", tx_ready_o, 0);
    @(negedge clk_i);
    check("R11 sck idle after disable", sck_o, 1);
    @(negedge clk_i);
    on_i = 1'b1;
    repeat (40) @(negedge clk_i);
    check("R11 no word from aborted transfer", rx_cnt, 0);
    check("R11 ready again when on", tx_ready_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule